// File: doc/BRIEF.md
# Bus Abort Detector with Status Capture

This block watches every request on a shared 32-bit internal bus used by two masters. In the same cycle as the request, it decides whether the access must be refused. An access is refused for one of two reasons: the address is misaligned for the requested size, or the memory decode logic reports that no defined region claims the address. A refused access gets a cancel strobe toward the slaves. The abort is also driven to every master, whichever one issued it.

On the clock edge after an abort, the block records the full faulting address and a status word. The status word holds the size, the access type, the cause flags, the master that caused the abort, and sticky per-master flags. Together these tell a fault handler which masters have aborted since it last looked.

Software reads the two records through a small combinational read port. Reading the status word clears the flags that describe pending events. The address record is kept until the next abort.

Top module: `bus_abort_monitor`

## Requirements
- R1: A word access (size code 2'b10) whose address bits [1:0] are not both zero raises the abort and cancel outputs in the same cycle as the request.
- R2: A half-word access (size code 2'b01) with address bit 0 set is aborted and cancelled. Byte accesses (size 2'b00) and correctly aligned accesses are never aborted for alignment.
- R3: A code fetch (type 2'b10) issued by master 0, the processor, is never aborted for alignment. A code fetch from master 1 is checked like any other access.
- R4: When the decode-hit input is low during a valid request, the access is aborted. If the access is also misaligned, both cause flags are recorded.
- R5: Every bit of the per-master abort vector equals the cancel output. Both are low whenever no valid request is present.
- R6: After an abort, the address record (read select 0) holds the full 32-bit request address from the next clock edge on. Accesses that are not aborted, and register reads, leave it unchanged.
- R7: The status word (read select 1) is laid out as follows:
  - bits [1:0]: the size code of the last aborted access (00 byte, 01 half-word, 10 word).
  - bits [3:2]: its type code (00 data read, 01 data write, 10 code fetch).
  - bit 8: undefined-address cause.
  - bit 9: misaligned cause.
  - all other bits read as zero.
- R8: Status bits [17:16] name the master of the most recent abort, one-hot (bit 16 for master 0, bit 17 for master 1). At most one of these bits is set.
- R9: Status bits [25:24] are sticky per-master flags (bit 24 for master 0, bit 25 for master 1). A flag is set when a new abort overwrites a record of that master that has not yet been read, meaning a cause flag was still set.
- R10: A status read returns the values held before the read. At the following edge it clears the sticky flags and both cause flags, and keeps size, type and last master. If an abort arrives in the same cycle as the read, the new record is loaded and no sticky flag is set.
- R11: After reset, both records read as zero. The read data output is zero whenever the read enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | A bus request is present this cycle |
| req_addr | input | 32 | Request address |
| req_size | input | 2 | Access size: 00 byte, 01 half-word, 10 word |
| req_type | input | 2 | Access type: 00 data read, 01 data write, 10 code fetch |
| req_master | input | 1 | Issuing master; 0 is the processor |
| req_hit | input | 1 | Decode logic found a defined region for the address |
| abort_o | output | 2 | Abort broadcast, one copy per master |
| cancel_o | output | 1 | Cancels the current access at the slaves |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 1 | 0 selects the address record, 1 the status word |
| rd_data | output | 32 | Read data, combinational |

## Verification
The bench goes after the alignment corners:
- Odd byte addresses, which a design that checked every size would wrongly abort.
- Misaligned fetches from each master. A design that exempted every fetch would let the second master through. A design that exempted none would abort the processor.

It also sets up two aborts back to back without a read in between. This catches a design that marks the newest master as sticky instead of the master whose record was overwritten.

Finally, it reads the status twice, and reads it in the same cycle as an abort. A design that cleared the record before returning it, or let the clear override the fresh capture, would show up here.

// File: rtl/abm_pkg.sv
package abm_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    TY_READ  = 2'b00,
    TY_WRITE = 2'b01,
    TY_FETCH = 2'b10,
    TY_RSVD  = 2'b11
  } acc_type_e;

  // Status word field positions
  localparam int ST_SIZE_LSB   = 0;
  localparam int ST_TYPE_LSB   = 2;
  localparam int ST_UNDEF_BIT  = 8;
  localparam int ST_MISAL_BIT  = 9;
  localparam int ST_LAST_LSB   = 16;
  localparam int ST_STICKY_LSB = 24;
  localparam int ST_MAX_MST    = 8;

  typedef struct packed {
    logic undef;
    logic misal;
  } cause_t;

endpackage

// File: rtl/abm_rst_sync.sv
module abm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/abm_check.sv
module abm_check
  import abm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int MID_W  = 1,
  parameter int CPU_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        acc_type,
  input  logic [MID_W-1:0]  master,
  input  logic              hit,
  output cause_t            cause,
  output logic              abort_ev
);

  logic cpu_fetch;
  logic word_bad;
  logic half_bad;

  always_comb begin
    cpu_fetch = (acc_type == TY_FETCH) && (master == MID_W'(CPU_ID));
    word_bad  = (size == SZ_WORD) && (addr[1:0] != 2'b00);
    half_bad  = (size == SZ_HALF) && addr[0];

    cause.misal = valid && !cpu_fetch && (word_bad || half_bad);
    cause.undef = valid && !hit;
    abort_ev    = cause.misal || cause.undef;
  end

  AST_WORD_MISAL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_WORD && addr[1:0] != 2'b00 && acc_type != TY_FETCH) |-> abort_ev); // R1
  AST_HALF_MISAL_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && size == SZ_HALF && addr[0] && acc_type != TY_FETCH) |-> abort_ev); // R2
  AST_CPU_FETCH_EXEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && hit && acc_type == TY_FETCH && master == MID_W'(CPU_ID)) |-> !abort_ev); // R3
  AST_UNDEF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !hit) |-> abort_ev); // R4
  AST_IDLE_NO_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> !abort_ev); // R5

endmodule

// File: rtl/abm_capture.sv
module abm_capture
  import abm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_M  = 2,
  parameter int MID_W  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_ev,
  input  cause_t            cause,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic [1:0]        acc_type,
  input  logic [MID_W-1:0]  master,
  input  logic              clr,
  output logic [ADDR_W-1:0] addr_q,
  output logic [1:0]        size_q,
  output logic [1:0]        type_q,
  output cause_t            cause_q,
  output logic [NUM_M-1:0]  last_q,
  output logic [NUM_M-1:0]  sticky_q
);

  logic              pending;
  logic              rec_en;
  logic              cause_en;
  logic [ADDR_W-1:0] addr_d;
  logic [1:0]        size_d;
  logic [1:0]        type_d;
  cause_t            cause_d;
  logic [NUM_M-1:0]  last_d;

  // Next-state for the record fields
  always_comb begin
    pending  = cause_q.undef || cause_q.misal;
    rec_en   = abort_ev;
    cause_en = abort_ev || clr;
    addr_d   = addr;
    size_d   = size;
    type_d   = acc_type;
    if (abort_ev) begin
      cause_d = cause;
    end else begin
      cause_d = '0;
    end
    for (int i = 0; i < NUM_M; i++) begin
      last_d[i] = (master == MID_W'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      size_q <= '0;
      type_q <= '0;
      last_q <= '0;
    end else if (rec_en) begin
      addr_q <= addr_d;
      size_q <= size_d;
      type_q <= type_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q <= '0;
    end else if (cause_en) begin
      cause_q <= cause_d;
    end
  end

  // One sticky flag per master
  for (genvar g = 0; g < NUM_M; g++) begin : g_sticky
    logic stk_d;
    logic stk_q;

    always_comb begin
      stk_d = stk_q;
      if (clr) begin
        stk_d = 1'b0;
      end else if (abort_ev && pending && last_q[g]) begin
        stk_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stk_q <= 1'b0;
      end else begin
        stk_q <= stk_d;
      end
    end

    assign sticky_q[g] = stk_q;
  end

  AST_ADDR_CAPTURED: assert property (@(posedge clk) disable iff (!rst_n)
    abort_ev |=> (addr_q == $past(addr))); // R6
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !abort_ev |=> $stable(addr_q)); // R6
  AST_LAST_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(last_q)); // R8
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_ev && !clr && (cause_q.undef || cause_q.misal))
      |=> ((sticky_q & $past(last_q)) == $past(last_q))); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !abort_ev) |=> (sticky_q == '0 && !cause_q.undef && !cause_q.misal)); // R10
  AST_READ_KEEPS_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !abort_ev) |=> ($stable(size_q) && $stable(type_q) && $stable(last_q))); // R10

endmodule

// File: rtl/abm_rdmux.sv
module abm_rdmux
  import abm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_M  = 2
) (
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [1:0]        size_q,
  input  logic [1:0]        type_q,
  input  cause_t            cause_q,
  input  logic [NUM_M-1:0]  last_q,
  input  logic [NUM_M-1:0]  sticky_q,
  output logic [31:0]       rd_data
);

  logic [31:0] status_w;
  logic [31:0] addr_w;

  always_comb begin
    status_w = '0;
    status_w[ST_SIZE_LSB +: 2]       = size_q;
    status_w[ST_TYPE_LSB +: 2]       = type_q;
    status_w[ST_UNDEF_BIT]           = cause_q.undef;
    status_w[ST_MISAL_BIT]           = cause_q.misal;
    status_w[ST_LAST_LSB +: NUM_M]   = last_q;
    status_w[ST_STICKY_LSB +: NUM_M] = sticky_q;

    addr_w = '0;
    addr_w[ADDR_W-1:0] = addr_q;

    if (!rd_en) begin
      rd_data = '0;
    end else if (rd_sel) begin
      rd_data = status_w;
    end else begin
      rd_data = addr_w;
    end
  end

endmodule

// File: rtl/bus_abort_monitor.sv
module bus_abort_monitor
  import abm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NUM_M  = 2,
  parameter int CPU_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [1:0]        req_type,
  input  logic [((NUM_M > 1) ? $clog2(NUM_M) : 1)-1:0] req_master,
  input  logic              req_hit,
  output logic [NUM_M-1:0]  abort_o,
  output logic              cancel_o,
  input  logic              rd_en,
  input  logic              rd_sel,
  output logic [31:0]       rd_data
);

  localparam int MID_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;

  logic              rst_i_n;
  cause_t            cause;
  logic              abort_ev;
  logic              clr;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [1:0]        type_q;
  cause_t            cause_q;
  logic [NUM_M-1:0]  last_q;
  logic [NUM_M-1:0]  sticky_q;

  abm_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  abm_check #(.ADDR_W(ADDR_W), .MID_W(MID_W), .CPU_ID(CPU_ID)) u_check (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .valid    (req_valid),
    .addr     (req_addr),
    .size     (req_size),
    .acc_type (req_type),
    .master   (req_master),
    .hit      (req_hit),
    .cause    (cause),
    .abort_ev (abort_ev)
  );

  assign clr      = rd_en && rd_sel;
  assign abort_o  = {NUM_M{abort_ev}};
  assign cancel_o = abort_ev;

  abm_capture #(.ADDR_W(ADDR_W), .NUM_M(NUM_M), .MID_W(MID_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .abort_ev (abort_ev),
    .cause    (cause),
    .addr     (req_addr),
    .size     (req_size),
    .acc_type (req_type),
    .master   (req_master),
    .clr      (clr),
    .addr_q   (addr_q),
    .size_q   (size_q),
    .type_q   (type_q),
    .cause_q  (cause_q),
    .last_q   (last_q),
    .sticky_q (sticky_q)
  );

  abm_rdmux #(.ADDR_W(ADDR_W), .NUM_M(NUM_M)) u_rd (
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .addr_q   (addr_q),
    .size_q   (size_q),
    .type_q   (type_q),
    .cause_q  (cause_q),
    .last_q   (last_q),
    .sticky_q (sticky_q),
    .rd_data  (rd_data)
  );

  initial begin
    AST_MASTER_FIELD_FITS: assert (NUM_M <= ST_MAX_MST && ADDR_W <= 32); // R8
  end

  AST_CANCEL_WITH_BCAST: assert property (@(posedge clk) disable iff (!rst_i_n)
    cancel_o |-> (abort_o[NUM_M-1] && abort_o[0])); // R5

endmodule

// File: tb/bus_abort_monitor_tb.sv
module bus_abort_monitor_tb;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic [1:0]  req_type;
  logic [0:0]  req_master;
  logic        req_hit;
  logic [1:0]  abort_o;
  logic        cancel_o;
  logic        rd_en;
  logic        rd_sel;
  logic [31:0] rd_data;

  int n_chk;
  int n_err;
  bit done;

  // Reference model of the records
  logic [31:0] m_addr;
  logic [1:0]  m_size;
  logic [1:0]  m_type;
  logic        m_undef;
  logic        m_misal;
  logic [1:0]  m_last;
  logic [1:0]  m_stk;

  bus_abort_monitor u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .req_size   (req_size),
    .req_type   (req_type),
    .req_master (req_master),
    .req_hit    (req_hit),
    .abort_o    (abort_o),
    .cancel_o   (cancel_o),
    .rd_en      (rd_en),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] stat_word();
    logic [31:0] w;
    w = '0;
    w[1:0]   = m_size;
    w[3:2]   = m_type;
    w[8]     = m_undef;
    w[9]     = m_misal;
    w[17:16] = m_last;
    w[25:24] = m_stk;
    return w;
  endfunction

  function automatic logic exp_misal(input logic [31:0] a, input logic [1:0] sz,
                                     input logic [1:0] ty, input logic mst);
    if (ty == 2'b10 && mst == 1'b0) return 1'b0;
    if (sz == 2'b10) return a[1:0] != 2'b00;
    if (sz == 2'b01) return a[0];
    return 1'b0;
  endfunction

  function automatic void model_capture(input logic [31:0] a, input logic [1:0] sz,
                                        input logic [1:0] ty, input logic mst,
                                        input logic un, input logic mi, input bit read_now);
    if (read_now) m_stk = 2'b00;
    else if (m_undef || m_misal) m_stk = m_stk | m_last;
    m_addr  = a;
    m_size  = sz;
    m_type  = ty;
    m_undef = un;
    m_misal = mi;
    m_last  = mst ? 2'b10 : 2'b01;
  endfunction

  // One bus request, optionally with a status read in the same cycle
  task automatic access(input string tag, input logic [31:0] a, input logic [1:0] sz,
                        input logic [1:0] ty, input logic mst, input logic hit,
                        input bit with_read);
    logic un;
    logic mi;
    logic ab;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_size = sz; req_type = ty;
    req_master = mst; req_hit = hit;
    rd_en = with_read; rd_sel = 1'b1;
    un = !hit;
    mi = exp_misal(a, sz, ty, mst);
    ab = un || mi;
    #1;
    check({tag, " abort"}, {29'd0, abort_o, cancel_o}, {29'd0, ab, ab, ab});
    if (with_read) check({tag, " read data"}, rd_data, stat_word());
    @(posedge clk);
    #1;
    req_valid = 1'b0; rd_en = 1'b0;
    if (ab) model_capture(a, sz, ty, mst, un, mi, with_read);
    else if (with_read) begin m_stk = 2'b00; m_undef = 1'b0; m_misal = 1'b0; end
  endtask

  task automatic read_reg(input string tag, input logic sel);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    #1;
    check(tag, rd_data, sel ? stat_word() : m_addr);
    @(posedge clk);
    #1;
    rd_en = 1'b0;
    if (sel) begin m_stk = 2'b00; m_undef = 1'b0; m_misal = 1'b0; end
  endtask

  task automatic t_reset();
    check("R11 idle rd_data", rd_data, 32'd0);
    read_reg("R11 reset address", 1'b0);
    read_reg("R11 reset status", 1'b1);
    check("R5 idle abort", {30'd0, abort_o}, 32'd0);
  endtask

  task automatic t_word();
    access("R1 word offset 2", 32'h2000_0102, 2'b10, 2'b00, 1'b1, 1'b1, 0);
    read_reg("R6 address of word abort", 1'b0);
    read_reg("R7 status of word abort", 1'b1);
    access("R1 word offset 3", 32'h2000_0003, 2'b10, 2'b01, 1'b0, 1'b1, 0);
    access("R1 aligned word", 32'h2000_0100, 2'b10, 2'b01, 1'b0, 1'b1, 0);
    read_reg("R6 address after clean access", 1'b0);
  endtask

  task automatic t_half_byte();
    read_reg("R10 flush before half", 1'b1);
    access("R2 odd half", 32'h3000_0011, 2'b01, 2'b01, 1'b1, 1'b1, 0);
    read_reg("R7 half status", 1'b1);
    access("R2 aligned half at offset 2", 32'h3000_0012, 2'b01, 2'b00, 1'b1, 1'b1, 0);
    access("R2 odd byte", 32'h3000_0013, 2'b00, 2'b01, 1'b0, 1'b1, 0);
  endtask

  task automatic t_fetch();
    access("R3 cpu fetch misaligned", 32'h0000_0402, 2'b10, 2'b10, 1'b0, 1'b1, 0);
    read_reg("R3 address untouched by cpu fetch", 1'b0);
    access("R3 other master fetch misaligned", 32'h0000_0406, 2'b10, 2'b10, 1'b1, 1'b1, 0);
    read_reg("R7 fetch status", 1'b1);
  endtask

  task automatic t_undef();
    access("R4 undefined aligned", 32'hF000_0000, 2'b10, 2'b00, 1'b0, 1'b0, 0);
    read_reg("R4 undefined status", 1'b1);
    access("R4 undefined and misaligned", 32'hF000_0001, 2'b01, 2'b01, 1'b1, 1'b0, 0);
    read_reg("R4 both causes", 1'b1);
    access("R4 cpu fetch undefined", 32'hF000_0002, 2'b10, 2'b10, 1'b0, 1'b0, 0);
    read_reg("R4 fetch undefined status", 1'b1);
  endtask

  task automatic t_sticky();
    read_reg("R10 flush before sticky", 1'b1);
    access("R9 first abort m0", 32'h4000_0001, 2'b10, 2'b00, 1'b0, 1'b1, 0);
    access("R9 second abort m1", 32'h4000_0003, 2'b01, 2'b01, 1'b1, 1'b1, 0);
    read_reg("R9 sticky m0 and last m1", 1'b1);
    read_reg("R10 second read cleared", 1'b1);
    read_reg("R6 address kept after read", 1'b0);
    access("R9 abort after read no sticky", 32'h4000_0005, 2'b10, 2'b00, 1'b1, 1'b1, 0);
    access("R9 repeat m1", 32'h4000_0009, 2'b01, 2'b00, 1'b1, 1'b1, 0);
    read_reg("R9 sticky m1", 1'b1);
  endtask

  task automatic t_same_cycle();
    access("R10 pending abort m0", 32'h5000_0002, 2'b10, 2'b00, 1'b0, 1'b1, 0);
    access("R10 abort with read", 32'h5000_0101, 2'b01, 2'b01, 1'b1, 1'b1, 1);
    read_reg("R10 new record no sticky", 1'b1);
    read_reg("R10 same-cycle address", 1'b0);
  endtask

  initial begin
    n_chk = 0; n_err = 0; done = 0;
    req_valid = 0; req_addr = '0; req_size = '0; req_type = '0;
    req_master = '0; req_hit = 1'b1; rd_en = 0; rd_sel = 0;
    m_addr = '0; m_size = '0; m_type = '0; m_undef = 0; m_misal = 0;
    m_last = '0; m_stk = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_word();
    t_half_byte();
    t_fetch();
    t_undef();
    t_sticky();
    t_same_cycle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R11 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule